// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer Cluster

This block holds one counter/timer per processor and a shared mode register that chooses, per processor, how each one behaves. In counter mode a unit counts up on every prescaler tick without pause. When the next count would reach a programmed limit, it folds back to zero, sets a reached flag and raises that processor's interrupt. Reading the limit back acknowledges the event. In user-timer mode the same register offsets instead expose a 63-bit count as a high and a low word. Software can load that count, start it and stop it, and it never interrupts.

Software reaches each processor's registers through a single-cycle register port. A processor window is picked with `bus_cpu` when `bus_sys` is low, and the word offset is byte offset divided by four. The shared mode register sits in the system window (`bus_sys` high) at word 4 (byte 0x10). The port accepts every access in the cycle it is presented. Read data is combinational in that same cycle. There is no back-pressure: a strobe is never stalled, and a read side effect takes place at the clock edge that ends the access. The tick input comes from a prescaler outside the block. One tick equals one step of count bit 9.

Top module: `dmtc_cluster`

## Requirements
- R1: After reset all mode bits are 0, every run flag is 1, and every count, limit, reached flag and interrupt is 0.
- R2: In counter mode a tick advances the 22-bit tick count (count bits 30:9) whatever the run flag holds. If the advanced value is at least the limit, the count returns to 0. A nonzero limit then also sets reached and raises the interrupt, while a zero limit free-runs, folding at 0x3FFFFF ticks without setting reached.
- R3: In counter mode a read of word 0 returns {0, limit[21:0], 9'b0} and clears reached and the interrupt. A read of word 1 returns {reached, count[21:0], 9'b0}.
- R4: In counter mode a write of word 0 takes wdata[30:9] as limit, zeroes the count and drops the interrupt. A write of word 2 takes the limit and keeps the count. A write of word 1 changes nothing.
- R5: A write of word 3 stores wdata[0] as the run flag in either mode. A read of word 3 returns the flag in bit 0 and zeros above it.
- R6: The mode register at system word 4 has bit i selecting user-timer mode (1) for processor i. A read returns the bits with zeros above.
- R7: In user mode the count advances on a tick only while run is 1. Word 0 reads {reached, count[62:32]} and word 1 reads count[31:0] with bits 8:0 zero. These reads change nothing.
- R8: In user mode a write of word 0 loads count[62:32] from wdata[30:0], and a write of word 1 loads count[31:9] from wdata[31:9]. Either write clears reached. A write of word 2 is ignored.
- R9: In user mode a step that would bring the count to 0x7FFFFFFFFFFFFE00 wraps it to 0 and sets reached. A processor in user mode never asserts its interrupt.
- R10: When a mode bit goes 0 to 1, that interrupt drops and the limit is forced to all ones (reads 0x7FFFFE00). When it goes 1 to 0, counting resumes on ticks even if run is 0.
- R11: A mode bit written with its current value causes no action for that processor.
- R12: A write that loads the count, in the same cycle as a tick, takes precedence over that tick's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler step pulse, one count step |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sys | input | 1 | 1 selects the system window (mode register) |
| bus_cpu | input | SEL_W | Processor window index |
| bus_word | input | 3 | Word offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | NPROC | Per-processor interrupt, level |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that `bus_cpu` names an existing processor. Under those assumptions a falling interrupt can be tied to a register access and a rising one to a tick. The stimulus drives one access at a time and draws processor indices only from the instantiated range. The directed phase deliberately puts ticks alongside writes, so the priority rule between them is exercised rather than assumed.

// File: rtl/dmtc_pkg.sv
package dmtc_pkg;
  localparam int TICK_SHIFT = 9;                  // count bit that one tick steps
  localparam int CNT_W      = 63 - TICK_SHIFT;    // user count in tick units
  localparam int LIM_W      = 31 - TICK_SHIFT;    // counter-mode field in tick units
  localparam int HI_LSB     = 32 - TICK_SHIFT;    // first tick bit in the high word
  localparam logic [LIM_W-1:0] LIM_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  localparam logic [2:0] W_LIMIT = 3'd0;
  localparam logic [2:0] W_COUNT = 3'd1;
  localparam logic [2:0] W_LIMNR = 3'd2;
  localparam logic [2:0] W_RUN   = 3'd3;
  localparam logic [2:0] W_MODE  = 3'd4;
endpackage

// File: rtl/dmtc_modectl.sv
module dmtc_modectl #(
  parameter int NPROC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPROC-1:0] wdata,
  output logic [NPROC-1:0] mode_q,
  output logic [NPROC-1:0] enter_user
);
  // R11: only bits that change produce an entry pulse
  always_comb enter_user = wr_en ? (wdata & ~mode_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= '0;      // R1
    else if (wr_en) mode_q <= wdata;   // R6
  end
endmodule

// File: rtl/dmtc_core.sv
module dmtc_core
  import dmtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        user_mode,
  input  logic        enter_user,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  word,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic             reached_q, run_q, irq_q;
  logic [LIM_W:0]   lo_next, wrap_at;
  logic             ctr_hit, usr_hit, step_en;

  always_comb begin
    lo_next = {1'b0, cnt_q[LIM_W-1:0]} + 1'b1;
    wrap_at = (lim_q == '0) ? {1'b0, LIM_MAX} : {1'b0, lim_q};
    ctr_hit = (lo_next >= wrap_at);                    // R2
    usr_hit = (cnt_q == CNT_MAX - 1'b1);               // R9
    step_en = tick & (~user_mode | run_q);             // R2 R7
  end

  always_comb begin
    unique case (word)
      W_LIMIT: rdata = user_mode ? {reached_q, cnt_q[CNT_W-1:HI_LSB]}
                                 : {1'b0, lim_q, {TICK_SHIFT{1'b0}}};
      W_COUNT: rdata = user_mode ? {cnt_q[HI_LSB-1:0], {TICK_SHIFT{1'b0}}}
                                 : {reached_q, cnt_q[LIM_W-1:0], {TICK_SHIFT{1'b0}}};
      W_RUN:   rdata = {31'b0, run_q};                 // R5
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin                                  // R1
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      run_q     <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      if (step_en) begin
        if (user_mode) begin
          if (usr_hit) begin
            cnt_q     <= '0;
            reached_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (ctr_hit) begin
          cnt_q <= '0;
          if (lim_q != '0) begin
            reached_q <= 1'b1;
            irq_q     <= 1'b1;
          end
        end else begin
          cnt_q <= {{(CNT_W-LIM_W){1'b0}}, lo_next[LIM_W-1:0]};
        end
      end
      if (rd_en && word == W_LIMIT && !user_mode) begin  // R3
        reached_q <= 1'b0;
        irq_q     <= 1'b0;
      end
      if (wr_en) begin                                 // R12: later assignments win
        unique case (word)
          W_LIMIT: begin
            if (user_mode) begin                       // R8
              cnt_q     <= {wdata[CNT_W-HI_LSB-1:0], cnt_q[HI_LSB-1:0]};
              reached_q <= 1'b0;
            end else begin                             // R4
              lim_q <= wdata[30:TICK_SHIFT];
              cnt_q <= '0;
              irq_q <= 1'b0;
            end
          end
          W_COUNT: begin
            if (user_mode) begin
              cnt_q     <= {cnt_q[CNT_W-1:HI_LSB], wdata[31:TICK_SHIFT]};
              reached_q <= 1'b0;
            end
          end
          W_LIMNR: if (!user_mode) lim_q <= wdata[30:TICK_SHIFT];
          W_RUN:   run_q <= wdata[0];
          default: ;
        endcase
      end
      if (enter_user) begin                            // R10
        irq_q <= 1'b0;
        lim_q <= LIM_MAX;
      end
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/dmtc_cluster.sv
module dmtc_cluster
  import dmtc_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int SEL_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sys,
  input  logic [SEL_W-1:0] bus_cpu,
  input  logic [2:0]       bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NPROC-1:0] irq
);
  logic [NPROC-1:0] mode_q, enter_user;
  logic [31:0]      core_rdata [NPROC];
  logic             mode_wr;

  assign mode_wr = bus_wr & bus_sys & (bus_word == W_MODE);

  dmtc_modectl #(.NPROC(NPROC)) mode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (mode_wr),
    .wdata      (bus_wdata[NPROC-1:0]),
    .mode_q     (mode_q),
    .enter_user (enter_user)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_core
    logic hit;
    assign hit = ~bus_sys & (bus_cpu == SEL_W'(p));
    dmtc_core core_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .user_mode  (mode_q[p]),
      .enter_user (enter_user[p]),
      .wr_en      (bus_wr & hit),
      .rd_en      (bus_rd & hit),
      .word       (bus_word),
      .wdata      (bus_wdata),
      .rdata      (core_rdata[p]),
      .irq        (irq[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sys) begin
      if (bus_word == W_MODE) bus_rdata = {{(32-NPROC){1'b0}}, mode_q};   // R6
    end else begin
      for (int p = 0; p < NPROC; p++)
        if (bus_cpu == SEL_W'(p)) bus_rdata = core_rdata[p];
    end
  end
endmodule

// File: rtl/dmtc_chk.sv
module dmtc_chk #(
  parameter int NPROC = 4,
  localparam int SEL_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_sys,
  input logic [SEL_W-1:0] bus_cpu,
  input logic [2:0]       bus_word,
  input logic [31:0]      bus_rdata,
  input logic [NPROC-1:0] irq,
  input logic [NPROC-1:0] mode_q
);
  AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & mode_q) == '0);                                              // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_sys && bus_word == 3'd0 && !mode_q[bus_cpu])
      |=> !irq[$past(bus_cpu)]);                                        // R3
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) != '0) |-> $past(tick));                       // R2
  AST_FALL_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq & $past(irq)) != '0) |-> $past(bus_rd || bus_wr));           // R10
  AST_RUN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_sys && bus_word == 3'd3) |-> bus_rdata[31:1] == '0); // R5
  AST_MODE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sys && bus_word == 3'd4) |-> bus_rdata[31:NPROC] == '0); // R6
endmodule

bind dmtc_cluster dmtc_chk #(.NPROC(NPROC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_sys   (bus_sys),
  .bus_cpu   (bus_cpu),
  .bus_word  (bus_word),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .mode_q    (mode_q)
);

// File: tb/dmtc_cluster_tb_top.sv
module dmtc_cluster_tb_top;
  localparam int NP = 4;
  localparam longint UMAX = (64'd1 << 54) - 1;
  localparam longint LMAX = 64'h3FFFFF;

  logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0, bus_rd = 0, bus_sys = 0;
  logic [1:0]  bus_cpu = 0;
  logic [2:0]  bus_word = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NP-1:0] irq;
  int total = 0, fails = 0;

  longint m_cnt [NP];
  longint m_lim [NP];
  bit     m_reach [NP];
  bit     m_run [NP];
  bit     m_irq [NP];
  bit [NP-1:0] m_mode;

  always #10 clk = ~clk;   // 50 MHz

  dmtc_cluster #(.NPROC(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sys(bus_sys), .bus_cpu(bus_cpu), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input bit sys, input int cpu, input int word);
    longint c;
    if (sys) return (word == 4) ? {28'b0, m_mode} : 32'h0;
    c = m_cnt[cpu];
    case (word)
      0: return m_mode[cpu] ? {m_reach[cpu], 31'(c >> 23)} : {1'b0, 22'(m_lim[cpu]), 9'b0};
      1: return m_mode[cpu] ? {23'(c), 9'b0} : {m_reach[cpu], 22'(c), 9'b0};
      3: return {31'b0, m_run[cpu]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_clk(bit tk, bit wr, bit rd, bit sys, int cpu, int word,
                                    logic [31:0] wd);
    bit [NP-1:0] old = m_mode;
    for (int p = 0; p < NP; p++) begin
      bit u = old[p];
      bit hitp = !sys && (cpu == p);
      if (tk && (!u || m_run[p])) begin
        if (u) begin
          if (m_cnt[p] == UMAX - 1) begin m_cnt[p] = 0; m_reach[p] = 1; end
          else m_cnt[p] = m_cnt[p] + 1;
        end else begin
          longint c = (m_cnt[p] & LMAX) + 1;
          longint w = (m_lim[p] == 0) ? LMAX : m_lim[p];
          if (c >= w) begin
            m_cnt[p] = 0;
            if (m_lim[p] != 0) begin m_reach[p] = 1; m_irq[p] = 1; end
          end else m_cnt[p] = c;
        end
      end
      if (rd && hitp && word == 0 && !u) begin m_reach[p] = 0; m_irq[p] = 0; end
      if (wr && hitp) begin
        case (word)
          0: if (u) begin
               m_cnt[p] = (m_cnt[p] & 64'h7FFFFF) | (longint'(wd[30:0]) << 23);
               m_reach[p] = 0;
             end else begin
               m_lim[p] = longint'(wd[30:9]); m_cnt[p] = 0; m_irq[p] = 0;
             end
          1: if (u) begin
               m_cnt[p] = (m_cnt[p] & ~64'h7FFFFF) | longint'(wd[31:9]);
               m_reach[p] = 0;
             end
          2: if (!u) m_lim[p] = longint'(wd[30:9]);
          3: m_run[p] = wd[0];
          default: ;
        endcase
      end
    end
    if (wr && sys && word == 4) begin
      for (int p = 0; p < NP; p++)
        if (wd[p] && !old[p]) begin m_irq[p] = 0; m_lim[p] = LMAX; end
      m_mode = wd[NP-1:0];
    end
  endfunction

  task automatic step(input bit tk, input bit wr, input bit rd, input bit sys, input int cpu,
                      input int word, input logic [31:0] wd, input string tag);
    logic [NP-1:0] ei;
    @(negedge clk);
    tick = tk; bus_wr = wr; bus_rd = rd; bus_sys = sys;
    bus_cpu = 2'(cpu); bus_word = 3'(word); bus_wdata = wd;
    #1;
    if (rd) check(bus_rdata, exp_rd(sys, cpu, word), tag);
    for (int p = 0; p < NP; p++) ei[p] = m_irq[p];
    check({28'b0, irq}, {28'b0, ei}, tag);
    @(posedge clk);
    model_clk(tk, wr, rd, sys, cpu, word, wd);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input bit sys, input int cpu, input int word, input logic [31:0] v, input string tag);
    step(0, 1, 0, sys, cpu, word, v, tag);
  endtask
  task automatic rd(input bit sys, input int cpu, input int word, input string tag);
    step(0, 0, 1, sys, cpu, word, 0, tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_cnt[p] = 0; m_lim[p] = 0; m_reach[p] = 0; m_run[p] = 1; m_irq[p] = 0;
    end
    m_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int p = 0; p < NP; p++) rd(0, p, 3, "R1");
    rd(0, 0, 1, "R1"); rd(0, 0, 0, "R1"); rd(1, 0, 4, "R1");

    // R2 limit match in counter mode
    wr(0, 0, 0, 5 << 9, "R4");
    ticks(4, "R2"); rd(0, 0, 1, "R2");
    ticks(1, "R2"); rd(0, 0, 1, "R2");
    // R3 acknowledge by reading the limit
    rd(0, 0, 0, "R3"); rd(0, 0, 1, "R3");

    // R4 limit without reset, ignored counter write
    wr(0, 1, 0, 10 << 9, "R4"); ticks(6, "R4");
    wr(0, 1, 2, 8 << 9, "R4"); ticks(1, "R4"); rd(0, 1, 1, "R4");
    ticks(1, "R4"); wr(0, 1, 1, 32'h0001_2000, "R4"); rd(0, 1, 1, "R4");
    rd(0, 1, 0, "R4");

    // R5 run flag stored; counter mode ignores it
    wr(0, 3, 3, 0, "R5"); rd(0, 3, 3, "R5"); ticks(2, "R5"); rd(0, 3, 1, "R5");

    // R6 mode register
    wr(1, 0, 4, 32'h8, "R6"); rd(1, 0, 4, "R6");

    // R7 user count gated by run, reads without side effect
    ticks(3, "R7"); rd(0, 3, 1, "R7");
    wr(0, 3, 3, 1, "R7"); ticks(3, "R7"); rd(0, 3, 1, "R7"); rd(0, 3, 0, "R7"); rd(0, 3, 0, "R7");

    // R8 word loads
    wr(0, 3, 0, 32'h1234_5678, "R8"); wr(0, 3, 1, 32'hABCD_E200, "R8");
    rd(0, 3, 0, "R8"); rd(0, 3, 1, "R8");
    wr(0, 3, 2, 32'h5555_5555, "R8"); rd(0, 3, 0, "R8"); rd(0, 3, 1, "R8");

    // R9 top of the user range
    wr(0, 3, 0, 32'h7FFF_FFFF, "R9"); wr(0, 3, 1, 32'hFFFF_FC00, "R9");
    ticks(1, "R9"); rd(0, 3, 0, "R9"); rd(0, 3, 1, "R9");

    // R10 entry drops interrupt, exit resumes counting
    wr(0, 0, 0, 2 << 9, "R10"); ticks(2, "R10");
    wr(1, 0, 4, 32'h9, "R10"); step(0, 0, 0, 0, 0, 0, 0, "R10");
    wr(0, 0, 3, 0, "R10"); ticks(2, "R10"); rd(0, 0, 1, "R10");
    wr(1, 0, 4, 32'h8, "R10"); ticks(2, "R10"); rd(0, 0, 1, "R10"); rd(0, 0, 0, "R10");

    // R11 unchanged mode bit keeps a pending interrupt
    wr(0, 1, 0, 1 << 9, "R11"); ticks(1, "R11");
    wr(1, 0, 4, 32'h8, "R11"); step(0, 0, 0, 0, 0, 0, 0, "R11"); rd(1, 0, 4, "R11");

    // R2 free-run fold at zero limit, no reached
    wr(1, 0, 4, 32'hC, "R2"); wr(0, 2, 0, 0, "R2"); wr(0, 2, 1, 32'h3FFFFD << 9, "R2");
    wr(1, 0, 4, 32'h8, "R2"); wr(0, 2, 2, 0, "R2");
    ticks(1, "R2"); rd(0, 2, 1, "R2"); ticks(1, "R2"); rd(0, 2, 1, "R2");

    // R12 count load beats a simultaneous tick
    step(1, 1, 0, 0, 3, 1, 32'h0000_0400, "R12"); rd(0, 3, 1, "R12");

    // mixed traffic against the model
    for (int i = 0; i < 800; i++) begin
      int op = $urandom_range(0, 9);
      int cpu = $urandom_range(0, NP - 1);
      int word = $urandom_range(0, 4);
      bit tk = $urandom_range(0, 1);
      logic [31:0] v = $urandom;
      if (op < 3) step(tk, 0, 0, 0, 0, 0, 0, "R2");
      else if (op < 6) step(tk, 0, 1, (word == 4), cpu, word, 0, "R7");
      else if (op == 9) step(tk, 1, 0, 1, 0, 4, v & 32'hF, "R6");
      else begin
        if (word == 0 || word == 2) v = ($urandom_range(1, 12) << 9) | (v & 32'h1FF);
        if (word == 4) word = 3;
        step(tk, 1, 0, 0, cpu, word, v, "R8");
      end
    end

    @(negedge clk); tick = 0; bus_wr = 0; bus_rd = 0;
    summary();
    $finish;
  end
endmodule